// File: doc/BRIEF.md
# Serial Configuration Register Write Port

This block gives a host a write-only path into a bank of byte-wide configuration registers over a three-wire serial link. The three wires are an active-low select, a serial clock and a data line. All three are sampled by the block's own system clock: each passes through a synchronizer, and the block finds edges in the synchronized copies. Data bits are captured on rising serial-clock edges, most significant bit first. The current register contents are driven out as one flat parallel bus.

A transfer opens when select falls and closes when select rises. The first byte of a transfer is an identity byte. It must carry the 7-bit chip address 0010000 followed by a write flag of 0, which makes the byte 0x20. If it does not match, the block ignores the rest of the transfer. The second byte is a pointer byte. Its top bit turns on auto-increment, and its low four bits pick the target register. Every byte after that is written to the register the pointer selects. With auto-increment on, the pointer steps to the next register after each data byte. With it off, further bytes overwrite the same register.

Top module: `spi_cfg_port`

## Requirements
- R1: After reset every register in the bank reads 0, and the pointer and the auto-increment flag are 0.
- R2: Bits are sampled on rising serial-clock edges while select is low, most significant bit first, and each complete data byte is written to the register the pointer selects.
- R3: A first byte other than 0x20 causes the block to ignore every later byte until select rises. This includes 0x21, which carries the read flag. No register changes in that case.
- R4: In the pointer byte, bit 7 is the auto-increment enable, bits 3:0 are the register index, and bits 6:4 have no effect.
- R5: With auto-increment enabled, the pointer advances by one after each data byte and wraps from register 15 to register 0.
- R6: With auto-increment disabled, successive data bytes in one transfer all overwrite the same register.
- R7: When select rises, an incomplete byte is discarded and no register is written with it. The next transfer starts again with the identity byte.
- R8: Serial-clock edges while select is high change nothing.
- R9: A register write appears on the outputs exactly three system-clock cycles after the rising serial-clock edge that completes the byte reaches the pin. This assumes the default two-stage synchronizer.
- R10: At most one register changes per data byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples all serial inputs |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cs_n | input | 1 | Active-low transfer select |
| spi_sclk | input | 1 | Serial clock; data is sampled on its rising edge |
| spi_sdi | input | 1 | Serial data in, most significant bit first |
| cfg_regs | output | NUM_REGS*DATA_W | Register bank contents; register i occupies bits [i*8+7:i*8] |

## Verification
A corrupted pointer or auto-increment flag shows up as a byte landing in the wrong slot of `cfg_regs`, three cycles after the final bit of that byte. A phase or bit-count error shows up on the same cycle as a write that should not happen or a write that never arrives. Rejected identity bytes, partial bytes and clocks sent while select is high are covered this way. The bench compares all sixteen registers on every system clock against a model that applies each expected write on its exact cycle. Any such fault is therefore reported on the first cycle on which it becomes visible.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CHIP,
        PH_PTR,
        PH_DATA,
        PH_SKIP
    } phase_e;
endpackage

// File: rtl/spi_cfg_sync.sv
module spi_cfg_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RST_VAL}};
            prev_q  <= RST_VAL;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], din};
            prev_q  <= chain_q[STAGES-1];
        end
    end

    assign dout = chain_q[STAGES-1];
    assign rise = chain_q[STAGES-1] & ~prev_q;
    assign fall = ~chain_q[STAGES-1] & prev_q;
endmodule

// File: rtl/spi_cfg_regbank.sv
module spi_cfg_regbank #(
    parameter int NUM_REGS = 16,
    parameter int DATA_W   = 8,
    localparam int ADDR_W  = $clog2(NUM_REGS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [DATA_W-1:0]          wr_data,
    output logic [NUM_REGS*DATA_W-1:0] regs_flat
);
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        logic [DATA_W-1:0] val_q;
        logic [DATA_W-1:0] val_d;

        always_comb begin
            val_d = val_q;
            if (wr_en && (wr_addr == ADDR_W'(i))) val_d = wr_data;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) val_q <= '0;
            else        val_q <= val_d;
        end

        assign regs_flat[i*DATA_W +: DATA_W] = val_q;
    end
endmodule

// File: rtl/spi_cfg_port.sv
module spi_cfg_port
    import spi_cfg_pkg::*;
#(
    parameter int         NUM_REGS    = 16,
    parameter int         DATA_W      = 8,
    parameter int         SYNC_STAGES = 2,
    parameter logic [6:0] CHIP_ADDR   = 7'b0010000,
    localparam int        ADDR_W      = $clog2(NUM_REGS),
    localparam int        BIT_W       = $clog2(DATA_W)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       spi_cs_n,
    input  logic                       spi_sclk,
    input  logic                       spi_sdi,
    output logic [NUM_REGS*DATA_W-1:0] cfg_regs
);
    localparam logic [DATA_W-1:0] ID_WRITE = DATA_W'({CHIP_ADDR, 1'b0});
    localparam logic [BIT_W-1:0]  LAST_BIT = BIT_W'(DATA_W - 1);
    localparam logic [ADDR_W-1:0] TOP_REG  = ADDR_W'(NUM_REGS - 1);

    typedef struct packed {
        phase_e            phase;
        logic [BIT_W-1:0]  bitcnt;
        logic [DATA_W-1:0] shreg;
        logic              incr;
        logic [ADDR_W-1:0] ptr;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    logic cs_s, cs_rise_unused, cs_fall;
    logic sclk_s_unused, sclk_rise, sclk_fall_unused;
    logic sdi_s, sdi_rise_unused, sdi_fall_unused;

    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] byte_in;

    spi_cfg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cs (
        .clk(clk), .rst_n(rst_n), .din(spi_cs_n),
        .dout(cs_s), .rise(cs_rise_unused), .fall(cs_fall)
    );
    spi_cfg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sclk (
        .clk(clk), .rst_n(rst_n), .din(spi_sclk),
        .dout(sclk_s_unused), .rise(sclk_rise), .fall(sclk_fall_unused)
    );
    spi_cfg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sdi (
        .clk(clk), .rst_n(rst_n), .din(spi_sdi),
        .dout(sdi_s), .rise(sdi_rise_unused), .fall(sdi_fall_unused)
    );

    always_comb begin
        ctrl_d  = ctrl_q;
        wr_en   = 1'b0;
        wr_addr = ctrl_q.ptr;
        byte_in = {ctrl_q.shreg[DATA_W-2:0], sdi_s};
        wr_data = byte_in;

        if (cs_s) begin
            // select released: drop any partial byte
            ctrl_d.phase  = PH_IDLE;
            ctrl_d.bitcnt = '0;
        end else if (cs_fall) begin
            ctrl_d.phase  = PH_CHIP;
            ctrl_d.bitcnt = '0;
        end else if (sclk_rise && ctrl_q.phase != PH_IDLE) begin
            ctrl_d.shreg  = byte_in;
            ctrl_d.bitcnt = ctrl_q.bitcnt + 1'b1;
            if (ctrl_q.bitcnt == LAST_BIT) begin
                ctrl_d.bitcnt = '0;
                unique case (ctrl_q.phase)
                    PH_CHIP: ctrl_d.phase = (byte_in == ID_WRITE) ? PH_PTR : PH_SKIP;
                    PH_PTR: begin
                        ctrl_d.incr  = byte_in[DATA_W-1];
                        ctrl_d.ptr   = byte_in[ADDR_W-1:0];
                        ctrl_d.phase = PH_DATA;
                    end
                    PH_DATA: begin
                        wr_en = 1'b1;
                        if (ctrl_q.incr)
                            ctrl_d.ptr = (ctrl_q.ptr == TOP_REG) ? '0 : ctrl_q.ptr + 1'b1;
                    end
                    default: ctrl_d.phase = ctrl_q.phase;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '{phase: PH_IDLE, bitcnt: '0, shreg: '0, incr: 1'b0, ptr: '0};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    spi_cfg_regbank #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .regs_flat(cfg_regs)
    );
endmodule

// File: rtl/spi_cfg_port_chk.sv
module spi_cfg_port_chk #(
    parameter int NUM_REGS = 16,
    parameter int DATA_W   = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       spi_cs_n,
    input logic                       spi_sclk,
    input logic [NUM_REGS*DATA_W-1:0] cfg_regs
);
    logic [NUM_REGS*DATA_W-1:0] prev_q;
    logic [NUM_REGS-1:0]        chg;
    logic                       was_rst_q;
    logic                       sclk_prev_q;
    logic                       pin_rise_q;
    logic [1:0]                 hi_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q      <= '0;
            was_rst_q   <= 1'b1;
            sclk_prev_q <= 1'b0;
            pin_rise_q  <= 1'b0;
            hi_cnt_q    <= '0;
        end else begin
            prev_q      <= cfg_regs;
            was_rst_q   <= 1'b0;
            sclk_prev_q <= spi_sclk;
            pin_rise_q  <= spi_sclk & ~sclk_prev_q;
            if (!spi_cs_n)          hi_cnt_q <= '0;
            else if (hi_cnt_q != 2'd3) hi_cnt_q <= hi_cnt_q + 2'd1;
        end
    end

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_chg
        assign chg[i] = cfg_regs[i*DATA_W +: DATA_W] != prev_q[i*DATA_W +: DATA_W];
    end

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        was_rst_q |-> cfg_regs == '0);

    assert_single_reg_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(chg) <= 1);

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_cnt_q >= 2'd2) |=> $stable(cfg_regs));

    assert_write_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_regs) |-> $past(pin_rise_q, 2));
endmodule

bind spi_cfg_port spi_cfg_port_chk #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .cfg_regs(cfg_regs)
);

// File: tb/spi_cfg_port_tb.sv
module spi_cfg_port_tb;
    localparam int HALF = 6;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         spi_cs_n;
    logic         spi_sclk;
    logic         spi_sdi;
    logic [127:0] cfg_regs;

    int    total = 0;
    int    bad   = 0;
    int    ncyc  = 0;
    string cur_req = "R1";

    logic [7:0] exp_reg [16];
    int         m_idx;
    bit         m_ok;
    bit         m_incr;
    int         m_ptr;

    always #2 clk = ~clk;

    spi_cfg_port u_dut (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n),
        .spi_sclk(spi_sclk), .spi_sdi(spi_sdi), .cfg_regs(cfg_regs)
    );

    always @(posedge clk) begin
        if (ncyc > 150000) begin
            bad++;
            $display("FAIL watchdog: run hung, actual cycles=%0d expected<150000", ncyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic tick();
        bit hit;
        @(negedge clk);
        ncyc++;
        total++;
        hit = 0;
        for (int i = 0; i < 16; i++) begin
            if (!hit && cfg_regs[i*8 +: 8] !== exp_reg[i]) begin
                hit = 1;
                $display("FAIL %s cycle %0d reg%0d: actual=%02h expected=%02h",
                         cur_req, ncyc, i, cfg_regs[i*8 +: 8], exp_reg[i]);
            end
        end
        if (hit) bad++;
    endtask

    task automatic ticks(int n);
        for (int k = 0; k < n; k++) tick();
    endtask

    // behavioural model: consume one completed byte of the open transfer
    task automatic model_byte(logic [7:0] b);
        if (m_idx == 0) m_ok = (b == 8'h20);
        else if (m_ok) begin
            if (m_idx == 1) begin
                m_incr = b[7];
                m_ptr  = int'(b[3:0]);
            end else begin
                exp_reg[m_ptr] = b;
                if (m_incr) m_ptr = (m_ptr + 1) % 16;
            end
        end
        m_idx++;
    endtask

    // send the top n bits of b; model updated only when the byte completes with select low
    task automatic send_bits(logic [7:0] b, int n);
        for (int k = 0; k < n; k++) begin
            spi_sdi = b[7-k];
            ticks(HALF);
            spi_sclk = 1'b1;
            ticks(2);
            if (k == 7 && !spi_cs_n) model_byte(b);
            ticks(HALF - 2);
            spi_sclk = 1'b0;
        end
    endtask

    task automatic send_byte(logic [7:0] b);
        send_bits(b, 8);
    endtask

    task automatic cs_open();
        spi_cs_n = 1'b0;
        m_idx = 0;
        ticks(HALF);
    endtask

    task automatic cs_close();
        ticks(HALF);
        spi_cs_n = 1'b1;
        ticks(HALF);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) exp_reg[i] = 8'h00;
        m_idx = 0; m_ok = 0; m_incr = 0; m_ptr = 0;
        rst_n = 1'b0; spi_cs_n = 1'b1; spi_sclk = 1'b0; spi_sdi = 1'b0;
        ticks(4);
        rst_n = 1'b1;
        cur_req = "R1 reset state";
        ticks(6);

        // R2 R9: plain write, checked on the exact update cycle
        cur_req = "R2 R9 single write";
        cs_open(); send_byte(8'h20); send_byte(8'h03); send_byte(8'hA5); cs_close();

        // R6: fixed pointer overwrite
        cur_req = "R6 fixed pointer";
        cs_open(); send_byte(8'h20); send_byte(8'h05);
        send_byte(8'h11); send_byte(8'h22); send_byte(8'h33); cs_close();

        // R5 R10: burst with wrap 14,15,0,1
        cur_req = "R5 R10 burst wrap";
        cs_open(); send_byte(8'h20); send_byte(8'h8E);
        send_byte(8'h01); send_byte(8'h02); send_byte(8'h03); send_byte(8'h04); cs_close();

        // R4: reserved bits 6:4 set, increment off
        cur_req = "R4 reserved pointer bits";
        cs_open(); send_byte(8'h20); send_byte(8'h72);
        send_byte(8'h5A); send_byte(8'h6B); cs_close();

        // R3: read flag and wrong address both rejected
        cur_req = "R3 bad identity";
        cs_open(); send_byte(8'h21); send_byte(8'h80); send_byte(8'h99); cs_close();
        cs_open(); send_byte(8'h40); send_byte(8'h07); send_byte(8'h77); cs_close();
        cs_open(); send_byte(8'hA0); send_byte(8'h20); send_byte(8'h08); send_byte(8'h66); cs_close();

        // R7: partial data byte dropped; partial pointer byte then fresh transfer
        cur_req = "R7 partial byte";
        cs_open(); send_byte(8'h20); send_byte(8'h09); send_bits(8'hFF, 3); cs_close();
        cs_open(); send_byte(8'h20); send_bits(8'h0A, 5); cs_close();
        cs_open(); send_byte(8'h0B); send_byte(8'hDD); cs_close();
        cs_open(); send_byte(8'h20); send_byte(8'h0B); send_byte(8'hDD); cs_close();

        // R8: clocks with select high
        cur_req = "R8 select high";
        send_byte(8'h20); send_byte(8'h0C); send_byte(8'hEE);
        ticks(10);

        // R5 burst across whole bank after idle clocks
        cur_req = "R5 R10 full burst";
        cs_open(); send_byte(8'h20); send_byte(8'h80);
        for (int i = 0; i < 17; i++) send_byte(8'(8'h30 + i));
        cs_close();

        // R2: MSB-first distinct pattern
        cur_req = "R2 bit order";
        cs_open(); send_byte(8'h20); send_byte(8'h06); send_byte(8'h81); cs_close();

        ticks(10);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule